// File: doc/BRIEF.md
# Bank-Switched Dual-Port Memory

This block is a dual-port word memory split into four equal banks. Each bank has one static owner select input, and that input hands the bank to either the left or the right port. Each port has its own chip enable, write enable, byte enables, address and data. An access reaches storage only when the issuing port owns the bank that its address falls in. Writes from the other port are dropped without notice. Reads from the other port return a fixed filler word.

Each port accepts one access in every cycle in which its chip enable is high, so the block never applies back-pressure. A read is answered one cycle later by a registered data word and a one-cycle read-valid strobe. That strobe is the only valid signal on the output side, and no ready input exists, so the consumer must take the word on the cycle it is presented. The two ports can work at full rate at the same time, provided they address different banks that each of them owns. System software moves a bank between ports by flipping its select input. It must do this only while the bank is idle, and the other three banks keep running through the change.

Top module: `banked_dpram`

## Requirements
- R1: The top two address bits pick the bank. Bank 0 is the lowest quarter of the address space and bank 3 the highest. The remaining bits pick the word inside the bank.
- R2: Select input bit b set to 1 gives bank b to the left port. Set to 0, it gives bank b to the right port. Ownership is judged from the select value present in the cycle of the access.
- R3: A write by the owning port updates only the bytes whose enable is set. Enable bit 1 covers data bits 15:8 and enable bit 0 covers bits 7:0. A byte whose enable is clear keeps its old value.
- R4: A write from a port that does not own the addressed bank leaves every memory word unchanged.
- R5: A read from a port that does not own the addressed bank returns the filler word FILL (default 16'hDEAD).
- R6: A read (chip enable high, write enable low) presents its data on the read-data output, with read-valid high, in the next cycle only.
- R7: The two ports can access two different banks in the same cycle, each owning its own bank, and both accesses complete.
- R8: A single port can own any number of banks from zero to four at once.
- R9: Changing the select input of one idle bank does not disturb accesses to the other banks in the same cycles. The words stored in the moved bank are visible to its new owner.
- R10: When no read was issued in a cycle, read-valid is low in the next cycle and read data keeps its previous value. After reset, both read-data outputs are 0 and both read-valid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the read registers |
| bank_sel | input | 4 | Owner per bank: 1 = left port, 0 = right port |
| l_ce | input | 1 | Left port access enable |
| l_we | input | 1 | Left port write (1) or read (0) |
| l_be | input | 2 | Left port byte enables |
| l_addr | input | ADDR_W | Left port word address |
| l_wdata | input | 16 | Left port write data |
| l_rdata | output | 16 | Left port registered read data |
| l_rvld | output | 1 | Left port read data valid |
| r_ce | input | 1 | Right port access enable |
| r_we | input | 1 | Right port write (1) or read (0) |
| r_be | input | 2 | Right port byte enables |
| r_addr | input | ADDR_W | Right port word address |
| r_wdata | input | 16 | Right port write data |
| r_rdata | output | 16 | Right port registered read data |
| r_rvld | output | 1 | Right port read data valid |

## Verification
Two kinds of event can fall in the same cycle. In the first, an owner accesses a bank while the other port's dropped write or filler read targets the same bank. In the second, one port runs traffic on its banks while the select input of a different, idle bank flips. The bench provokes both. It drives both ports in every cycle across full address sweeps under several ownership patterns, and it toggles one select bit while the other port keeps reading its own bank. Every answer is judged against a word array that the bench keeps itself, updated only for writes that the ownership rule allows and merged byte by byte.

// File: rtl/bdp_pkg.sv
package bdp_pkg;
  localparam int NBANK  = 4;
  localparam int BSEL_W = 2;
  localparam int WORD_W = 16;
  localparam int NBYTE  = WORD_W / 8;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [NBYTE-1:0]  bmask_t;
endpackage

// File: rtl/bdp_port_gate.sv
module bdp_port_gate
  import bdp_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter bit IS_LEFT = 1'b1
) (
  input  logic                     ce,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NBANK-1:0]         sel,
  output logic [BSEL_W-1:0]        bank,
  output logic [ADDR_W-BSEL_W-1:0] off,
  output logic                     owned,
  output logic                     rd,
  output logic                     wr
);
  // upper address bits pick the bank, the rest index the word
  assign bank = addr[ADDR_W-1 -: BSEL_W];
  assign off  = addr[ADDR_W-BSEL_W-1:0];

  // select high means left owns; right owns on low
  generate
    if (IS_LEFT) begin : g_left
      assign owned = sel[bank];
    end else begin : g_right
      assign owned = ~sel[bank];
    end
  endgenerate

  assign rd = ce & ~we;
  assign wr = ce & we;
endmodule

// File: rtl/bdp_bank.sv
module bdp_bank
  import bdp_pkg::*;
#(
  parameter int OFF_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             left_owns,
  input  logic             l_hit,
  input  logic [OFF_W-1:0] l_off,
  input  bmask_t           l_be,
  input  word_t            l_wd,
  input  logic             r_hit,
  input  logic [OFF_W-1:0] r_off,
  input  bmask_t           r_be,
  input  word_t            r_wd,
  output word_t            l_q,
  output word_t            r_q
);
  localparam int DEPTH = 1 << OFF_W;

  word_t mem [DEPTH];

  logic             wen;
  logic [OFF_W-1:0] woff;
  bmask_t           wbe;
  word_t            wd;

  // the owner alone steers the single write path of this bank
  always_comb begin
    if (left_owns) begin
      wen = l_hit; woff = l_off; wbe = l_be; wd = l_wd;
    end else begin
      wen = r_hit; woff = r_off; wbe = r_be; wd = r_wd;
    end
  end

  always_ff @(posedge clk) begin
    if (wen) begin
      for (int b = 0; b < NBYTE; b++) begin
        if (wbe[b]) mem[woff][b*8 +: 8] <= wd[b*8 +: 8];
      end
    end
  end

  assign l_q = mem[l_off];
  assign r_q = mem[r_off];

  // R4: a foreign write with no owner write this cycle leaves the word alone
  a_r4_right_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (left_owns && r_hit && !l_hit) |=> (mem[$past(r_off)] === $past(r_q)));
  a_r4_left_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (!left_owns && l_hit && !r_hit) |=> (mem[$past(l_off)] === $past(l_q)));
  // R3: a full-word owner write lands in the addressed word
  a_r3_left_full_write: assert property (@(posedge clk) disable iff (!rst_n)
    (left_owns && l_hit && (&l_be)) |=> (mem[$past(l_off)] == $past(l_wd)));
  a_r3_right_full_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!left_owns && r_hit && (&r_be)) |=> (mem[$past(r_off)] == $past(r_wd)));
endmodule

// File: rtl/bdp_rd_port.sv
module bdp_rd_port
  import bdp_pkg::*;
#(
  parameter word_t FILL = 16'hDEAD
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rd,
  input  logic  owned,
  input  word_t q_in,
  output word_t rdata,
  output logic  rvld
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
      rvld  <= 1'b0;
    end else begin
      rvld <= rd;
      if (rd) rdata <= owned ? q_in : FILL;
    end
  end

  // R5: foreign reads answer with the filler word
  a_r5_filler: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !owned) |=> (rdata == FILL));
  // R6: every read is answered exactly one cycle later
  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rvld);
  // R10: idle cycles keep the data and drop valid
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> (!rvld && $stable(rdata)));
endmodule

// File: rtl/banked_dpram.sv
module banked_dpram
  import bdp_pkg::*;
#(
  parameter int    ADDR_W = 6,
  parameter word_t FILL   = 16'hDEAD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        bank_sel,
  input  logic              l_ce,
  input  logic              l_we,
  input  logic [1:0]        l_be,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [15:0]       l_wdata,
  output logic [15:0]       l_rdata,
  output logic              l_rvld,
  input  logic              r_ce,
  input  logic              r_we,
  input  logic [1:0]        r_be,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [15:0]       r_wdata,
  output logic [15:0]       r_rdata,
  output logic              r_rvld
);
  localparam int OFF_W = ADDR_W - BSEL_W;

  logic [BSEL_W-1:0] l_bank, r_bank;
  logic [OFF_W-1:0]  l_off, r_off;
  logic              l_own, r_own, l_rd, r_rd, l_wr, r_wr;

  bdp_port_gate #(.ADDR_W(ADDR_W), .IS_LEFT(1'b1)) u_gate_l (
    .ce(l_ce), .we(l_we), .addr(l_addr), .sel(bank_sel),
    .bank(l_bank), .off(l_off), .owned(l_own), .rd(l_rd), .wr(l_wr)
  );
  bdp_port_gate #(.ADDR_W(ADDR_W), .IS_LEFT(1'b0)) u_gate_r (
    .ce(r_ce), .we(r_we), .addr(r_addr), .sel(bank_sel),
    .bank(r_bank), .off(r_off), .owned(r_own), .rd(r_rd), .wr(r_wr)
  );

  word_t bq_l [NBANK];
  word_t bq_r [NBANK];

  generate
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
      logic l_hit, r_hit;
      assign l_hit = l_wr && (l_bank == BSEL_W'(g));
      assign r_hit = r_wr && (r_bank == BSEL_W'(g));
      bdp_bank #(.OFF_W(OFF_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .left_owns(bank_sel[g]),
        .l_hit(l_hit), .l_off(l_off), .l_be(l_be), .l_wd(l_wdata),
        .r_hit(r_hit), .r_off(r_off), .r_be(r_be), .r_wd(r_wdata),
        .l_q(bq_l[g]), .r_q(bq_r[g])
      );
    end
  endgenerate

  bdp_rd_port #(.FILL(FILL)) u_rd_l (
    .clk(clk), .rst_n(rst_n), .rd(l_rd), .owned(l_own),
    .q_in(bq_l[l_bank]), .rdata(l_rdata), .rvld(l_rvld)
  );
  bdp_rd_port #(.FILL(FILL)) u_rd_r (
    .clk(clk), .rst_n(rst_n), .rd(r_rd), .owned(r_own),
    .q_in(bq_r[r_bank]), .rdata(r_rdata), .rvld(r_rvld)
  );

  // R2: both ports never own the same bank at once
  a_r2_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (l_ce && r_ce && (l_bank == r_bank)) |-> (l_own != r_own));
endmodule

// File: tb/banked_dpram_test.sv
module banked_dpram_test;
  localparam int AW = 6;
  localparam logic [15:0] FILL = 16'hDEAD;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] sel = 4'hF;
  logic l_ce = 0, l_we = 0, r_ce = 0, r_we = 0;
  logic [1:0] l_be = 0, r_be = 0;
  logic [AW-1:0] l_addr = 0, r_addr = 0;
  logic [15:0] l_wdata = 0, r_wdata = 0;
  logic [15:0] l_rdata, r_rdata;
  logic l_rvld, r_rvld;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] model [NW];

  always #10 clk = ~clk;

  banked_dpram #(.ADDR_W(AW), .FILL(FILL)) uut (
    .clk(clk), .rst_n(rst_n), .bank_sel(sel),
    .l_ce(l_ce), .l_we(l_we), .l_be(l_be), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_rvld(l_rvld),
    .r_ce(r_ce), .r_we(r_we), .r_be(r_be), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_rvld(r_rvld)
  );

  function automatic logic [15:0] pat(int a);
    return 16'h1000 + 16'(a) * 16'h0103;
  endfunction

  function automatic logic [15:0] merge(logic [15:0] old, logic [15:0] nw, logic [1:0] be);
    logic [15:0] m = old;
    if (be[1]) m[15:8] = nw[15:8];
    if (be[0]) m[7:0]  = nw[7:0];
    return m;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle on both ports; ce low on a port when its op is 0 (idle), 1 read, 2 write
  task automatic cyc(string sec,
                     int lop, int la, logic [1:0] lbe, logic [15:0] lwd,
                     int rop, int ra, logic [1:0] rbe, logic [15:0] rwd);
    logic [15:0] lprev = l_rdata;
    logic [15:0] rprev = r_rdata;
    logic lown, rown;
    l_ce = (lop != 0); l_we = (lop == 2); l_addr = AW'(la); l_be = lbe; l_wdata = lwd;
    r_ce = (rop != 0); r_we = (rop == 2); r_addr = AW'(ra); r_be = rbe; r_wdata = rwd;
    lown = sel[la >> (AW-2)];
    rown = !sel[ra >> (AW-2)];
    @(posedge clk);
    @(negedge clk);
    if (lop == 1) begin
      check({sec, " R6 left valid"}, {15'b0, l_rvld}, 16'd1);
      check(lown ? {sec, " R2 left owned read"} : {sec, " R5 left foreign read"},
            l_rdata, lown ? model[la] : FILL);
    end else begin
      check({sec, " R10 left idle valid"}, {15'b0, l_rvld}, 16'd0);
      check({sec, " R10 left idle hold"}, l_rdata, lprev);
    end
    if (rop == 1) begin
      check({sec, " R6 right valid"}, {15'b0, r_rvld}, 16'd1);
      check(rown ? {sec, " R2 right owned read"} : {sec, " R5 right foreign read"},
            r_rdata, rown ? model[ra] : FILL);
    end else begin
      check({sec, " R10 right idle valid"}, {15'b0, r_rvld}, 16'd0);
      check({sec, " R10 right idle hold"}, r_rdata, rprev);
    end
    if (lop == 2 && lown) model[la] = merge(model[la], lwd, lbe);
    if (rop == 2 && rown) model[ra] = merge(model[ra], rwd, rbe);
    l_ce = 0; r_ce = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset left data", l_rdata, 16'h0);
    check("R10 reset right data", r_rdata, 16'h0);
    check("R10 reset valids", {14'b0, l_rvld, r_rvld}, 16'h0);
    rst_n = 1'b1;

    // all four banks to the left port; right writes are foreign
    sel = 4'hF;
    for (int a = 0; a < NW; a++) cyc("R8 R4", 2, a, 2'b11, pat(a), 2, NW-1-a, 2'b11, 16'hFFFF);
    for (int a = 0; a < NW; a++) cyc("R1 R8", 1, a, 2'b00, 16'h0, 1, a, 2'b00, 16'h0);
    cyc("R10", 0, 0, 2'b00, 16'h0, 0, 0, 2'b00, 16'h0);

    // zero banks for the left port: right now sees the old words
    sel = 4'h0;
    for (int a = 0; a < NW; a++) cyc("R9 R4", 2, a, 2'b11, 16'h0BAD, 1, a, 2'b00, 16'h0);
    for (int a = 0; a < NW; a++) cyc("R3", 1, a, 2'b00, 16'h0, 2, a, 2'(a), ~pat(a));
    for (int a = 0; a < NW; a++) cyc("R3 R5", 1, NW-1-a, 2'b00, 16'h0, 1, a, 2'b00, 16'h0);

    // split ownership: left has banks 0 and 1, right has 2 and 3
    sel = 4'b0011;
    for (int o = 0; o < NW/4; o++)
      cyc("R7 write", 2, o, 2'b11, 16'h4000 + 16'(o), 2, 3*(NW/4) + o, 2'b11, 16'h7000 + 16'(o));
    for (int o = 0; o < NW/4; o++)
      cyc("R7 read", 1, o, 2'b00, 16'h0, 1, 3*(NW/4) + o, 2'b00, 16'h0);
    for (int o = 0; o < NW/4; o++)
      cyc("R7 mixed", 1, NW/4 + o, 2'b00, 16'h0, 2, 2*(NW/4) + o, 2'b01, 16'h00A0 + 16'(o));

    // bank 2 moves to the left while both ports keep working elsewhere
    for (int i = 0; i < NW/4; i++) begin
      if (i == 8) sel[2] = 1'b1;
      cyc("R9 move", (i % 2 == 0) ? 1 : 2, i, 2'b11, 16'h5500 + 16'(i),
          1, 3*(NW/4) + i, 2'b00, 16'h0);
    end
    for (int o = 0; o < NW/4; o++)
      cyc("R9 new owner", 1, 2*(NW/4) + o, 2'b00, 16'h0, 1, 2*(NW/4) + o, 2'b00, 16'h0);
    for (int o = 0; o < NW/4; o++)
      cyc("R9 R4", 1, 2*(NW/4) + o, 2'b00, 16'h0, 2, 2*(NW/4) + o, 2'b11, 16'hEEEE);
    cyc("R10", 0, 0, 2'b00, 16'h0, 0, 0, 2'b00, 16'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule